// File: doc/BRIEF.md
# Reset Origin Flag

This block lets software tell, right after it starts running, whether the preceding reset was a power failure or only a chip-enable reset. It keeps a single readable flag that a small free-running prescaler sets on each of its carry pulses. A companion disable flip-flop, which only the two hard reset sources can set, blocks that setting until software reads the flag for the first time.

After a power-on clear or an external reset, the flag is therefore 0, and it stays 0 until software reads it. After a chip-enable reset, the flag keeps whatever the running system last gave it, which is normally 1. Boot code reads the flag once. A value of 0 means memory and ports must be initialised; a value of 1 means they still hold valid contents. Each read also consumes the flag, so later reads report one carry event each.

The two hard reset inputs take effect at once, asynchronously, and are released through a two-stage synchronizer. The chip-enable reset is a synchronous input. Its only effect here is to restart the prescaler.

Top module: `reset_origin_flag`

## Requirements
- R1: While `por_clear` is high, `carry_flag` reads 0 without waiting for a clock edge, and the disable flip-flop is set.
- R2: While the disable flip-flop is set, prescaler carry pulses leave `carry_flag` at 0.
- R3: A cycle with `flag_rd` high clears the disable flip-flop at the clock edge that ends that cycle. A carry pulse in that same cycle is still blocked.
- R4: Once the disable flip-flop is clear, a carry pulse sets `carry_flag`, and the flag is visible in the cycle after the pulse.
- R5: `ext_reset` acts on the flag, the disable flip-flop and the prescaler exactly as `por_clear` does.
- R6: During a cycle with `flag_rd` high, `carry_flag` shows the value from before the read. The read clears the flag at the edge that ends that cycle.
- R7: If an enabled carry pulse and `flag_rd` fall in the same cycle, the flag ends up 1.
- R8: A `ce_reset` pulse leaves `carry_flag` and the disable flip-flop unchanged, and resets the prescaler count to 0.
- R9: Both hard resets release at the second clock edge after both inputs are low, with the prescaler count at 0. The prescaler counts up by one each cycle and raises a one-cycle carry pulse in the cycle where the count holds its maximum value, 2^PRE_W-1. With the default PRE_W = 4, that pulse falls in the 16th cycle of counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_clear | input | 1 | Power-on clear, active high, asynchronous assert |
| ext_reset | input | 1 | External reset pin, active high, asynchronous assert |
| ce_reset | input | 1 | Chip-enable reset, active high, synchronous; restarts the prescaler only |
| flag_rd | input | 1 | CPU read strobe for the flag, one cycle per read |
| carry_flag | output | 1 | Readable carry flag |

## Verification
The bench steers a read into the exact cycle of a carry pulse twice. The first time, the disable flip-flop is still set, so a design that lets the read's clearing take effect too early would raise the flag. The second time, the flip-flop is clear, so a design that lets the clear win would lose the carry event. It fires a chip-enable reset while the flag is 1 and again while the flip-flop is set. A design that treats that reset like a hard one would clear the flag or unblock it, and a design that does not restart the prescaler would set the flag in the wrong cycle. The bench also checks the release timing and the carry period cycle by cycle, so an off-by-one in the synchronizer or the counter wrap shows up as a flag that rises one cycle early or late.

// File: rtl/rof_pkg.sv
package rof_pkg;

    // Registered state of the flag core
    typedef struct packed {
        logic flag;   // readable carry flag
        logic dis;    // carry-disable flip-flop
    } rof_core_t;

    localparam rof_core_t ROF_CORE_RST = '{flag: 1'b0, dis: 1'b1};

endpackage

// File: rtl/rof_rst_sync.sv
module rof_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,      // active high, asynchronous assert
    output logic rst_n      // asserted at once, released after STAGES edges
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sync_q <= '0;
        else      sync_q <= sync_d;
    end

    assign rst_n = sync_q[STAGES-1];

    // R9: release only after the first stage has already come out of reset
    a_r9_release_order: assert property (@(posedge clk) $rose(rst_n) |-> sync_q[0]);
endmodule

// File: rtl/rof_prescaler.sv
module rof_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,       // synchronous restart of the count
    output logic carry
);
    localparam logic [PRE_W-1:0] CNT_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] cnt_d;

    always_comb begin
        if (clr) cnt_d = '0;
        else     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign carry = (cnt_q == CNT_MAX);

    // R9: the carry pulse lasts exactly one cycle
    a_r9_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);
    // R9: the count wraps to zero after the pulse
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt_q == '0));
    // R8: a restart returns the count to zero
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/rof_flag_core.sv
module rof_flag_core
    import rof_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic carry,
    input  logic rd,
    output logic flag
);
    rof_core_t st_q;
    rof_core_t st_d;

    always_comb begin
        st_d = st_q;
        if (rd)
            st_d.dis = 1'b0;
        if (carry && !st_q.dis)
            st_d.flag = 1'b1;        // a set outranks the clearing read
        else if (rd)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ROF_CORE_RST;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R2: a set disable flip-flop keeps a clear flag clear
    a_r2_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dis && !st_q.flag) |=> !st_q.flag);
    // R3: a read releases the disable flip-flop
    a_r3_read_enables: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> !st_q.dis);
    // R6: a read with no carry leaves the flag clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !carry) |=> !st_q.flag);
    // R7: an enabled carry always lands, even beside a read
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !st_q.dis) |=> st_q.flag);
endmodule

// File: rtl/reset_origin_flag.sv
module reset_origin_flag #(
    parameter int PRE_W     = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic clk,
    input  logic por_clear,
    input  logic ext_reset,
    input  logic ce_reset,
    input  logic flag_rd,
    output logic carry_flag
);
    logic hard_rst;
    logic rst_n;
    logic carry_w;

    assign hard_rst = por_clear | ext_reset;

    rof_rst_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .arst  (hard_rst),
        .rst_n (rst_n)
    );

    rof_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ce_reset),
        .carry (carry_w)
    );

    rof_flag_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .carry (carry_w),
        .rd    (flag_rd),
        .flag  (carry_flag)
    );

    // R1/R5: a hard reset forces the flag low at once
    a_r1_hard_clear: assert property (@(posedge clk) hard_rst |-> !carry_flag);
    // R8: a chip-enable reset with no read or carry leaves the flag alone
    a_r8_ce_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_reset && !flag_rd && !carry_w) |=> $stable(carry_flag));
endmodule

// File: tb/reset_origin_flag_tb_top.sv
module reset_origin_flag_tb_top;
    localparam int PW   = 4;
    localparam int MAXC = (1 << PW) - 1;

    typedef struct {
        bit    exp;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic por_clear = 1'b1;
    logic ext_reset = 1'b0;
    logic ce_reset  = 1'b0;
    logic flag_rd   = 1'b0;
    logic carry_flag;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t sb_q[$];

    // reference state, built from the requirements
    bit m_flag;
    bit m_dis;
    int m_cnt;

    always #2 clk = ~clk;

    reset_origin_flag #(.PRE_W(PW)) dut_i (
        .clk        (clk),
        .por_clear  (por_clear),
        .ext_reset  (ext_reset),
        .ce_reset   (ce_reset),
        .flag_rd    (flag_rd),
        .carry_flag (carry_flag)
    );

    task automatic compare(bit act, bit exp, string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: carry_flag=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: one expected item per clock, checked away from the edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(carry_flag, e.exp, e.tag);
        end
    end

    // driver: one clock with the given strobes, then push the expected flag
    task automatic cyc(bit rd, bit ce, string tag);
        bit carry;
        exp_t e;
        @(negedge clk);
        #1;
        flag_rd  = rd;
        ce_reset = ce;
        @(posedge clk);
        carry = (m_cnt == MAXC);
        if (carry && !m_dis) m_flag = 1'b1;
        else if (rd)         m_flag = 1'b0;
        if (rd) m_dis = 1'b0;
        m_cnt = ce ? 0 : (m_cnt + 1) % (MAXC + 1);
        e.exp = m_flag;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, tag);
    endtask

    // step until the next cycle is the carry cycle
    task automatic to_carry_slot(string tag);
        while (m_cnt != MAXC) cyc(1'b0, 1'b0, tag);
    endtask

    task automatic hard_reset(bit use_pin, string tag);
        @(negedge clk);
        #1;
        flag_rd  = 1'b0;
        ce_reset = 1'b0;
        if (use_pin) ext_reset = 1'b1;
        else         por_clear = 1'b1;
        #0.5;
        compare(carry_flag, 1'b0, tag);          // cleared before any edge
        @(negedge clk);
        compare(carry_flag, 1'b0, tag);
        #1;
        por_clear = 1'b0;
        ext_reset = 1'b0;
        @(posedge clk);
        @(posedge clk);                          // second edge: release
        m_flag = 1'b0;
        m_dis  = 1'b1;
        m_cnt  = 0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        // R1: flag low while power-on clear is held
        #1;
        compare(carry_flag, 1'b0, "R1");
        hard_reset(1'b0, "R1");
        // R2: several carries pass while disabled
        idle(40, "R2");
        // R3: read in a carry cycle while disabled: still blocked
        to_carry_slot("R2");
        cyc(1'b1, 1'b0, "R3");
        // R4/R9: flag rises exactly one prescaler period later
        idle(20, "R4 R9");
        // R6: read shows 1, then flag is cleared
        cyc(1'b1, 1'b0, "R6");
        idle(3, "R6");
        // R7: read and carry together -> flag set
        to_carry_slot("R6");
        cyc(1'b1, 1'b0, "R7");
        idle(3, "R7");
        // R8: chip-enable reset keeps flag, restarts prescaler
        cyc(1'b0, 1'b1, "R8");
        idle(5, "R8");
        cyc(1'b1, 1'b0, "R8");
        idle(20, "R8 R9");
        // R5: external reset pin behaves as power-on clear
        hard_reset(1'b1, "R5");
        idle(10, "R5");
        cyc(1'b0, 1'b1, "R8");                   // disable stays set
        idle(40, "R5 R8");
        cyc(1'b1, 1'b0, "R5");
        idle(20, "R4");
        cyc(1'b1, 1'b0, "R6");
        idle(4, "R6");
        @(negedge clk);
        @(negedge clk);
        report();
    end
endmodule